// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a 16-bit successive-approximation converter with a three-wire serial port (chip-select, data clock, data out). A one-cycle start request drops chip-select. The block then produces a data clock from the system clock and captures the converter's output. It returns a right-aligned result with a one-cycle valid strobe and a frame-error flag. Between conversions it drives chip-select high, which lets the converter drop into its power-down state.

The data-clock half period is programmable in system-clock cycles. The block clamps it so that the data clock stays within the converter's 24 kHz to 2.4 MHz range and each phase lasts at least 200 ns. The number of result bits to keep is also programmable. Asking for fewer than 16 ends the frame early, right after the last wanted bit. In the optional check mode with a full word, the block keeps clocking through the converter's least-significant-bit-first repeat of the word. It flags any bit of that repeat that disagrees with the word already captured.

Top module: `adc_reader`

## Requirements
- R1: While rst_n is low, and at the first clock after reset, cs_n_o is 1, sclk_o is 0, valid_o is 0, result_o is 0, frame_err_o is 0 and overrun_o is 0.
- R2: A start_i seen high while the block is idle drives cs_n_o low at the next clock edge. sclk_o starts low and then alternates low and high phases, each exactly H system cycles long. sclk_o is always 0 while cs_n_o is 1.
- R3: Rising edges of sclk_o are numbered from 1 in each frame, and sdi_i is sampled at each of them. Edge 6 carries the null bit. Edges 7 to 22 carry result bits 15 down to 0, most significant first. Edges 23 to 37 carry the repeat, bits 1 up to 15.
- R4: With N = 16 and check mode off, a frame has FRAME_CLKS (default 24) rising edges, and result_o is the full 16-bit word in straight binary.
- R5: With N from 3 to 15, the frame ends after rising edge 6+N and result_o holds the top N bits right-aligned, with the upper bits 0. A keep_i below 3 counts as 3, and a keep_i above 16 counts as 16.
- R6: A null bit sampled as 1 at edge 6 sets frame_err_o for that frame.
- R7: With check mode on and N = 16, the frame has 37 rising edges, and frame_err_o is set if any repeat bit differs from the matching bit of the word. With N below 16, check mode has no effect.
- R8: valid_o is high for exactly one cycle, the cycle in which cs_n_o returns high at the end of a frame. result_o and frame_err_o keep their values until the next frame ends.
- R9: After a frame, cs_n_o stays high for at least 2H system cycles. A start_i that arrives during a frame or during this recovery time is ignored and sets overrun_o, which stays set until reset.
- R10: H is div_i clamped to [HALF_MIN, HALF_MAX]. HALF_MIN is the larger of ceil(SYS_CLK_HZ/4.8e6) and ceil(SYS_CLK_HZ/5e6). HALF_MAX is floor(SYS_CLK_HZ/48e3). At the default 48 MHz these are 10 and 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request |
| div_i | input | DIV_W (16) | Requested data-clock half period in system cycles |
| keep_i | input | KEEP_W (5) | Number of result bits to keep |
| verify_i | input | 1 | Check the least-significant-first repeat |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip-select, low during a frame |
| sclk_o | output | 1 | Data clock to the converter |
| result_o | output | 16 | Right-aligned result |
| valid_o | output | 1 | One-cycle strobe at the end of a frame |
| frame_err_o | output | 1 | Bad null bit or repeat mismatch in the last frame |
| overrun_o | output | 1 | Sticky flag for an ignored start request |

## Verification
A behavioural model of the converter drives sdi_i on each falling data-clock edge from a chosen word. The words include all zeros and all ones, which show whether a bit is lost or stuck. Alternating and asymmetric patterns show whether the bit order is reversed or off by one position.

Each word is read at full width, at several short widths and with out-of-range keep values, so that right-alignment and frame length can be told apart. A forced high null bit, and a single flipped bit in the repeat, each confirm that the error flag tracks the right cause. The flipped repeat bit is applied both with check mode on and with it off.

Divider values below, inside and above the legal range show whether the phase lengths follow the clamp. Start requests held high or pulsed mid-frame test the ignore rule, the sticky flag and the recovery gap.

// File: rtl/adc_rd_pkg.sv
// Package: shared constants and state type for the serial ADC readout
// controller. Edge numbers count data-clock rising edges from 1 in a frame.
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_GAP
    } rd_state_t;

    localparam int DATA_BITS   = 16;
    localparam int POS_W       = $clog2(DATA_BITS);
    localparam int NULL_EDGE   = 6;                          // edge carrying the null bit
    localparam int MSB_LAST    = NULL_EDGE + DATA_BITS;      // edge carrying bit 0
    localparam int REPLAY_LAST = NULL_EDGE + 2*DATA_BITS - 1; // edge carrying repeated bit 15
    localparam int MIN_KEEP    = 3;

endpackage

// File: rtl/adc_rd_baud.sv
// Module: adc_rd_baud
// Produces a one-cycle tick every HALF system cycles while run is high.
// Assumes half >= 1. The counter restarts whenever run is low, so the first
// tick comes exactly half cycles after run rises.
module adc_rd_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half - DIV_W'(1));

    // Count system cycles within one data-clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/adc_rd_seq.sv
// Module: adc_rd_seq
// Frame sequencer. It drives chip-select and the data clock, numbers the
// rising edges, signals the end of a frame and holds chip-select high for two
// phase ticks (one data-clock period) before it accepts the next start.
// Assumes last_edge stays stable during a frame.
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int EDGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [EDGE_W-1:0] last_edge,
    output logic              cs_n,
    output logic              sclk,
    output logic              accept,
    output logic              rise,
    output logic [EDGE_W-1:0] edge_idx,
    output logic              done,
    output logic              busy
);

    rd_state_t         state;
    logic [EDGE_W-1:0] edge_cnt;
    logic              gap_half;

    assign accept   = (state == ST_IDLE) && start;
    assign rise     = (state == ST_FRAME) && tick && !sclk;
    assign edge_idx = edge_cnt + EDGE_W'(1);
    assign done     = (state == ST_FRAME) && tick && sclk && (edge_cnt == last_edge);
    assign busy     = (state != ST_IDLE);

    // Step through idle, frame and recovery, toggling the data clock on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            edge_cnt <= '0;
            gap_half <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_FRAME;
                        cs_n     <= 1'b0;
                        sclk     <= 1'b0;
                        edge_cnt <= '0;
                    end
                end
                ST_FRAME: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk     <= 1'b1;
                            edge_cnt <= edge_cnt + EDGE_W'(1);
                        end else if (edge_cnt == last_edge) begin
                            sclk     <= 1'b0;
                            cs_n     <= 1'b1;
                            gap_half <= 1'b0;
                            state    <= ST_GAP;
                        end else begin
                            sclk <= 1'b0;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            state <= ST_IDLE;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cs_n  <= 1'b1;
                    sclk  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_rd_capture.sv
// Module: adc_rd_capture
// Samples serial data on each numbered rising edge. It checks the null bit,
// shifts in the kept result bits most significant first, and compares the
// least-significant-first repeat against the word when check mode is on.
// Assumes check_en is only set when all DATA_BITS bits are kept.
module adc_rd_capture
    import adc_rd_pkg::*;
#(
    parameter int EDGE_W = 6,
    parameter int KEEP_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 rise,
    input  logic [EDGE_W-1:0]    edge_idx,
    input  logic                 sdi,
    input  logic [KEEP_W-1:0]    keep_n,
    input  logic                 check_en,
    output logic [DATA_BITS-1:0] word,
    output logic                 err
);

    localparam logic [EDGE_W-1:0] E_NULL = EDGE_W'(NULL_EDGE);
    localparam logic [EDGE_W-1:0] E_MSB  = EDGE_W'(MSB_LAST);
    localparam logic [EDGE_W-1:0] E_REP  = EDGE_W'(REPLAY_LAST);

    logic              null_bad;
    logic              mismatch;
    logic [EDGE_W-1:0] keep_last;
    logic [POS_W-1:0]  rep_pos;
    logic              in_data;
    logic              in_replay;

    assign keep_last = E_NULL + EDGE_W'(keep_n);
    assign rep_pos   = POS_W'(edge_idx - E_MSB);
    assign in_data   = (edge_idx > E_NULL) && (edge_idx <= keep_last);
    assign in_replay = check_en && (edge_idx > E_MSB) && (edge_idx <= E_REP);
    assign err       = null_bad | mismatch;

    // Capture the null bit, the result bits and any repeat mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word     <= '0;
            null_bad <= 1'b0;
            mismatch <= 1'b0;
        end else if (rise) begin
            if (edge_idx == E_NULL) begin
                null_bad <= sdi;
            end
            if (in_data) begin
                word <= {word[DATA_BITS-2:0], sdi};
            end
            if (in_replay && (sdi != word[rep_pos])) begin
                mismatch <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_reader.sv
// Module: adc_reader (top)
// Host-side readout controller for a 16-bit serial converter. It clamps the
// requested divider and bit count, latches the configuration when a frame
// starts, runs the sequencer and capture logic, and registers the result.
// Assumes sdi_i is stable around each rising data-clock edge, which holds
// because the converter changes it on the falling edge, a full phase earlier.
module adc_reader
    import adc_rd_pkg::*;
#(
    parameter int SYS_CLK_HZ = 48_000_000,
    parameter int DIV_W      = 16,
    parameter int KEEP_W     = 5,
    parameter int FRAME_CLKS = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DIV_W-1:0]     div_i,
    input  logic [KEEP_W-1:0]    keep_i,
    input  logic                 verify_i,
    input  logic                 sdi_i,
    output logic                 cs_n_o,
    output logic                 sclk_o,
    output logic [DATA_BITS-1:0] result_o,
    output logic                 valid_o,
    output logic                 frame_err_o,
    output logic                 overrun_o
);

    localparam int HALF_FREQ = (SYS_CLK_HZ + 4_799_999) / 4_800_000;
    localparam int HALF_TIME = (SYS_CLK_HZ + 4_999_999) / 5_000_000;
    localparam int HALF_MIN  = (HALF_FREQ > HALF_TIME) ? HALF_FREQ : HALF_TIME;
    localparam int HALF_MAX  = SYS_CLK_HZ / 48_000;
    localparam int FULL_LAST = (FRAME_CLKS < MSB_LAST) ? MSB_LAST : FRAME_CLKS;
    localparam int TOP_EDGE  = (FULL_LAST > REPLAY_LAST) ? FULL_LAST : REPLAY_LAST;
    localparam int EDGE_W    = $clog2(TOP_EDGE + 1);

    logic [DIV_W-1:0]  half_eff, half_q;
    logic [KEEP_W-1:0] keep_eff, keep_q;
    logic              check_q;
    logic [EDGE_W-1:0] last_edge;
    logic              tick, accept, rise, done, busy;
    logic [EDGE_W-1:0] edge_idx;
    logic [DATA_BITS-1:0] cap_word;
    logic              cap_err;

    // Clamp the requested half period and bit count to legal values.
    always_comb begin
        if (div_i < DIV_W'(HALF_MIN)) begin
            half_eff = DIV_W'(HALF_MIN);
        end else if (div_i > DIV_W'(HALF_MAX)) begin
            half_eff = DIV_W'(HALF_MAX);
        end else begin
            half_eff = div_i;
        end
        if (keep_i < KEEP_W'(MIN_KEEP)) begin
            keep_eff = KEEP_W'(MIN_KEEP);
        end else if (keep_i > KEEP_W'(DATA_BITS)) begin
            keep_eff = KEEP_W'(DATA_BITS);
        end else begin
            keep_eff = keep_i;
        end
    end

    // Latch the frame configuration when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= DIV_W'(HALF_MIN);
            keep_q  <= KEEP_W'(DATA_BITS);
            check_q <= 1'b0;
        end else if (accept) begin
            half_q  <= half_eff;
            keep_q  <= keep_eff;
            check_q <= verify_i && (keep_eff == KEEP_W'(DATA_BITS));
        end
    end

    // Choose the last rising edge of the frame from the latched mode.
    always_comb begin
        if (check_q) begin
            last_edge = EDGE_W'(REPLAY_LAST);
        end else if (keep_q == KEEP_W'(DATA_BITS)) begin
            last_edge = EDGE_W'(FULL_LAST);
        end else begin
            last_edge = EDGE_W'(NULL_EDGE) + EDGE_W'(keep_q);
        end
    end

    adc_rd_baud #(
        .DIV_W (DIV_W)
    ) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .half  (half_q),
        .tick  (tick)
    );

    adc_rd_seq #(
        .EDGE_W (EDGE_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .tick      (tick),
        .last_edge (last_edge),
        .cs_n      (cs_n_o),
        .sclk      (sclk_o),
        .accept    (accept),
        .rise      (rise),
        .edge_idx  (edge_idx),
        .done      (done),
        .busy      (busy)
    );

    adc_rd_capture #(
        .EDGE_W (EDGE_W),
        .KEEP_W (KEEP_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .rise     (rise),
        .edge_idx (edge_idx),
        .sdi      (sdi_i),
        .keep_n   (keep_q),
        .check_en (check_q),
        .word     (cap_word),
        .err      (cap_err)
    );

    // Register the result, error flag and valid strobe at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o    <= '0;
            frame_err_o <= 1'b0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= done;
            if (done) begin
                result_o    <= cap_word;
                frame_err_o <= cap_err;
            end
        end
    end

    // Record a start request that arrives while busy; cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_o <= 1'b0;
        end else if (start_i && busy) begin
            overrun_o <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_reader_chk.sv
// Module: adc_reader_chk
// Protocol checker for adc_reader, attached with bind. It watches phase
// lengths, the chip-select recovery gap, the valid strobe and the sticky flag.
module adc_reader_chk #(
    parameter int HALF_MIN = 10,
    parameter int HALF_MAX = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cs_n_o,
    input logic sclk_o,
    input logic valid_o,
    input logic overrun_o
);

    localparam int GAP_MIN = 2 * HALF_MIN;
    localparam int PH_W    = $clog2(HALF_MAX + 2) + 1;
    localparam int GAP_W   = $clog2(GAP_MIN + 2) + 1;

    logic             sclk_q, cs_q;
    logic [PH_W-1:0]  phase_len;
    logic [GAP_W-1:0] high_len;

    // Track the previous levels, the current phase length and the high run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
            phase_len <= '0;
            high_len  <= GAP_W'(GAP_MIN);
        end else begin
            sclk_q <= sclk_o;
            cs_q   <= cs_n_o;
            if (cs_n_o) begin
                phase_len <= '0;
            end else if (sclk_o != sclk_q) begin
                phase_len <= PH_W'(1);
            end else if (phase_len != {PH_W{1'b1}}) begin
                phase_len <= phase_len + PH_W'(1);
            end
            if (!cs_n_o) begin
                high_len <= '0;
            end else if (high_len < GAP_W'(GAP_MIN)) begin
                high_len <= high_len + GAP_W'(1);
            end
        end
    end

    // R2: data clock stays low while chip-select is high
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R2: chip-select falls only in answer to a start request
    assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(start_i));

    // R10: every data-clock phase lies within the legal range
    assert_phase_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_q && (sclk_o != sclk_q)) |-> (phase_len >= PH_W'(HALF_MIN)));

    assert_phase_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_q && (sclk_o != sclk_q)) |-> (phase_len <= PH_W'(HALF_MAX)));

    // R8: valid appears only in the cycle chip-select returns high
    assert_valid_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && !cs_q));

    // R9: recovery gap of at least one data-clock period
    assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (high_len >= GAP_W'(GAP_MIN)));

    // R9: overrun flag is sticky
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

endmodule

bind adc_reader adc_reader_chk #(
    .HALF_MIN (HALF_MIN),
    .HALF_MAX (HALF_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cs_n_o    (cs_n_o),
    .sclk_o    (sclk_o),
    .valid_o   (valid_o),
    .overrun_o (overrun_o)
);

// File: tb/adc_reader_bench.sv
// Bench for adc_reader: a converter model, a port monitor, a vector table
// walked by one loop, then directed tests for reset, clamping and overrun.
module adc_reader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int H_MIN      = 10;
    localparam int H_MAX      = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] div_i = 16'd10;
    logic [4:0]  keep_i = 5'd16;
    logic        verify_i = 1'b0;
    logic        sdi = 1'b1;
    logic        cs_n_o, sclk_o, valid_o, frame_err_o, overrun_o;
    logic [15:0] result_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_reader u_adc_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .div_i       (div_i),
        .keep_i      (keep_i),
        .verify_i    (verify_i),
        .sdi_i       (sdi),
        .cs_n_o      (cs_n_o),
        .sclk_o      (sclk_o),
        .result_o    (result_o),
        .valid_o     (valid_o),
        .frame_err_o (frame_err_o),
        .overrun_o   (overrun_o)
    );

    // Converter model: data changes on falling data-clock edges.
    logic [15:0] m_word = 16'h0;
    logic        m_null = 1'b0;
    logic        m_flip = 1'b0;
    int          fcnt = 0;

    always @(negedge cs_n_o) begin
        fcnt = 0;
        sdi  = 1'b1;
    end

    always @(negedge sclk_o) begin
        fcnt = fcnt + 1;
        if (fcnt == 5)                      sdi = m_null;
        else if (fcnt >= 6 && fcnt <= 21)   sdi = m_word[21 - fcnt];
        else if (fcnt >= 22 && fcnt <= 36)  sdi = m_word[fcnt - 21] ^ (m_flip && fcnt == 30);
        else                                sdi = 1'b1;
    end

    // Port monitor: rising edges, phase lengths and chip-select high gap.
    bit prev_cs = 1'b1, prev_sclk = 1'b0;
    int rises = 0, phase_cnt = 0, ph_min = 0, ph_max = 0, hi_cnt = 0, gap_last = 0;

    always @(negedge clk) begin
        if (prev_cs && !cs_n_o) begin
            rises = 0; phase_cnt = 1; ph_min = 1000000; ph_max = 0; gap_last = hi_cnt;
        end else if (!prev_cs) begin
            if (sclk_o != prev_sclk) begin
                if (phase_cnt < ph_min) ph_min = phase_cnt;
                if (phase_cnt > ph_max) ph_max = phase_cnt;
                phase_cnt = 1;
                if (sclk_o) rises = rises + 1;
            end else begin
                phase_cnt = phase_cnt + 1;
            end
        end
        hi_cnt = cs_n_o ? hi_cnt + 1 : 0;
        prev_cs = cs_n_o;
        prev_sclk = sclk_o;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    // Run one frame and check it against values computed from the requirements.
    task automatic run_frame(input logic [15:0] word, input int keep, input bit ver,
                             input int div, input bit nbad, input bit rbad);
        int keff, heff, edges, exp_res, vcycles;
        bit vchk, exp_err;
        string tag;
        keff = (keep < 3) ? 3 : (keep > 16) ? 16 : keep;
        heff = (div < H_MIN) ? H_MIN : (div > H_MAX) ? H_MAX : div;
        vchk = ver && (keff == 16);
        edges = vchk ? 37 : (keff == 16) ? 24 : 6 + keff;
        exp_res = int'(word >> (16 - keff));
        exp_err = nbad || (vchk && rbad);
        tag = nbad ? "R6" : vchk ? "R7" : (keff < 16 || keep > 16) ? "R5" : "R4";
        m_word = word; m_null = nbad; m_flip = rbad;
        @(negedge clk);
        div_i = 16'(div); keep_i = 5'(keep); verify_i = ver; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        vcycles = 0;
        while (!valid_o && vcycles < 100000) begin
            @(negedge clk);
            vcycles++;
        end
        chk(tag, "result", int'(result_o), exp_res);
        chk(tag, "frame_err", int'(frame_err_o), int'(exp_err));
        @(negedge clk);
        chk("R8", "valid one cycle", int'(valid_o), 0);
        chk("R8", "result held", int'(result_o), exp_res);
        chk("R3", "rising edges", rises, edges);
        chk((div != heff) ? "R10" : "R2", "phase min", ph_min, heff);
        chk((div != heff) ? "R10" : "R2", "phase max", ph_max, heff);
        repeat (2 * heff + 2) @(negedge clk);
    endtask

    // Fields: word[39:24] keep[23:19] verify[18] div[17:2] null_bad[1] replay_flip[0]
    localparam logic [39:0] VECS [0:11] = '{
        {16'hA5C3, 5'd16, 1'b0, 16'd10, 1'b0, 1'b0},
        {16'h0000, 5'd16, 1'b0, 16'd10, 1'b0, 1'b0},
        {16'hFFFF, 5'd16, 1'b1, 16'd12, 1'b0, 1'b0},
        {16'h8001, 5'd16, 1'b1, 16'd10, 1'b0, 1'b0},
        {16'h7FFF, 5'd12, 1'b0, 16'd3,  1'b0, 1'b0},
        {16'hB6D9, 5'd3,  1'b0, 16'd15, 1'b0, 1'b0},
        {16'hD234, 5'd1,  1'b0, 16'd10, 1'b0, 1'b0},
        {16'hC3A5, 5'd31, 1'b0, 16'd11, 1'b0, 1'b0},
        {16'h4F1E, 5'd16, 1'b1, 16'd10, 1'b0, 1'b1},
        {16'h9ABC, 5'd16, 1'b0, 16'd10, 1'b1, 1'b0},
        {16'h9ABC, 5'd8,  1'b1, 16'd10, 1'b0, 1'b1},
        {16'h2468, 5'd16, 1'b0, 16'd10, 1'b0, 1'b1}
    };

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1", "cs_n in reset", int'(cs_n_o), 1);
        chk("R1", "sclk in reset", int'(sclk_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", int'(valid_o), 0);
        chk("R1", "result after reset", int'(result_o), 0);
        chk("R1", "frame_err after reset", int'(frame_err_o), 0);
        chk("R1", "overrun after reset", int'(overrun_o), 0);

        for (int i = 0; i < 12; i++) begin
            run_frame(VECS[i][39:24], int'(VECS[i][23:19]), VECS[i][18],
                      int'(VECS[i][17:2]), VECS[i][1], VECS[i][0]);
        end
        chk("R9", "no overrun from clean frames", int'(overrun_o), 0);

        // R10: divider above the legal range clamps to the maximum half period
        run_frame(16'hE1E1, 3, 1'b0, 5000, 1'b0, 1'b0);

        // R8: result held long after the strobe
        repeat (50) @(negedge clk);
        chk("R8", "result held later", int'(result_o), 7);
        chk("R8", "valid quiet later", int'(valid_o), 0);

        // R9: a start during a frame is ignored and sets the sticky flag
        m_word = 16'h3C5A; m_null = 1'b0; m_flip = 1'b0;
        div_i = 16'd10; keep_i = 5'd16; verify_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (100) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9", "cs stays low on ignored start", int'(cs_n_o), 0);
        chk("R9", "overrun set", int'(overrun_o), 1);
        while (!valid_o) @(negedge clk);
        chk("R9", "frame unaffected", int'(result_o), 16'h3C5A);
        @(negedge clk);
        chk("R9", "edges not restarted", rises, 24);

        // R9: start held high across frames; recovery gap and stickiness
        repeat (30) @(negedge clk);
        start_i = 1'b1;
        while (cs_n_o) @(negedge clk);
        while (!valid_o) @(negedge clk);
        while (cs_n_o) @(negedge clk);
        chk("R9", "gap at least 2H", int'(gap_last >= 2 * H_MIN), 1);
        start_i = 1'b0;
        while (!valid_o) @(negedge clk);
        repeat (30) @(negedge clk);
        chk("R9", "overrun still set", int'(overrun_o), 1);

        // R1: reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "overrun cleared by reset", int'(overrun_o), 0);
        chk("R1", "result cleared by reset", int'(result_o), 0);

        summary();
    end

endmodule